// File: doc/BRIEF.md
# Page Access Permission Checker

This block sits at the end of a page-table walk and decides whether one memory access may proceed. It takes the access type (write, instruction fetch), the privilege level, the 3-bit permission field and the modified bit of the leaf entry, and it also takes the result code of the walk. From these it computes a fault code or a set of granted rights (read, write, execute). The verdict is registered and appears one cycle after the request.

Every fault is logged in a fault status register, and the page-aligned faulting address is logged in a fault address register. If software has not read out an earlier fault before a new one arrives, the status register marks an overflow. A no-fault mode and a traps-disabled condition turn a fault into a full-rights grant instead of a trap. Software reads both registers through a small read port. Reading the status register clears it.

Top module: `page_perm_check`

## Requirements
- R1: The access class is the 3-bit value {acc_write, acc_fetch, acc_super}, with acc_write as bit 2 and acc_super as bit 0. A logged fault places this class in status bits 7:5.
- R2: Rights on the grant port are encoded as bit 0 = read, bit 1 = write, bit 2 = execute. Supervisor rights for permission codes 0..7 are R, RW, RX, RWX, X, RW, RX, RWX. User rights match these for codes 0..4. Code 5 gives a user R only, and codes 6 and 7 give a user nothing.
- R3: A read needs R, a fetch needs X, a write needs W, and a write-fetch needs both W and X. A missing right gives fault code 8 (protection). A user access to code 6 or 7 gives fault code 12 (privilege), and this code takes precedence.
- R4: On an allowed access, the write right is withheld while the entry's modified bit is 0.
- R5: When no-fault mode is set, a permission fault on a user access is suppressed. The user's rights are granted and the status register is left unchanged.
- R6: A non-zero walk result code is a fault whose code is that value, and the permission check is skipped. No-fault mode does not suppress it.
- R7: A fault ORs the class shifted left by 5, the fault code, and bit 1 (address valid) into the status register. It also loads the faulting address, with the low 12 bits cleared, into the address register. Without a fault, the address register holds its value.
- R8: When a fault arrives while the status register is non-zero, the register is first set to 1 (bit 0 = overflow), and the new fault is then ORed in.
- R9: When a fault occurs with no-fault mode set or traps disabled, the grant is RWX (7) and no trap is raised. Otherwise the grant is 0, and exactly one trap output is raised: ifault for a fetch, dfault for any other access.
- R10: The grant and trap outputs and resp_valid appear on the clock edge after a request. resp_valid is low after any cycle without a request.
- R11: rd_data shows the status register when rd_sel=0 and the address register when rd_sel=1. A status read clears the register, and a read of the address register clears nothing. If a status read and a fault happen in the same cycle, the read returns the old value, and the register then holds only the new fault, without the overflow bit.
- R12: After reset, both registers read 0 and resp_valid, grant, ifault and dfault are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | Access writes |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_super | input | 1 | Access is at supervisor level |
| perm_code | input | 3 | Permission field of the leaf entry |
| modified | input | 1 | Modified bit of the leaf entry |
| nofault_mode | input | 1 | No-fault mode enable |
| traps_en | input | 1 | Traps are enabled |
| walk_code | input | STAT_W | Walk result code, 0 when a leaf was found |
| fault_vaddr | input | ADDR_W | Virtual address of the access |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 = status register, 1 = address register |
| rd_data | output | ADDR_W | Read data |
| resp_valid | output | 1 | Verdict valid |
| grant | output | 3 | Granted rights {X, W, R} |
| ifault | output | 1 | Instruction fault trap |
| dfault | output | 1 | Data fault trap |

## Verification
On every cycle, the assertions check the invariants of the register side and the timing side. These are: one cycle of response latency, at most one trap output at a time, zero grant while a trap is raised, the valid flag and the overflow bit after a logged fault, clearing on a status read, and the address register holding its value between faults. The bench's scenarios cover the contents. It sweeps all 64 class and code pairs and checks the exact rights and fault codes from the permission maps. It also covers write masking by the modified bit, user-only suppression in no-fault mode, skipped checks on walk faults, and the field layout of the accumulated status. Only the bench shows the read-during-fault ordering.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

    localparam int RIGHTS_W = 3;
    localparam int RD_BIT   = 0;
    localparam int WR_BIT   = 1;
    localparam int EX_BIT   = 2;
    localparam int CLASS_W  = 3;
    localparam int CLASS_LSB = 5;

    typedef logic [RIGHTS_W-1:0] rights_t;

    localparam rights_t R_NONE = 3'b000;
    localparam rights_t R_R    = 3'b001;
    localparam rights_t R_RW   = 3'b011;
    localparam rights_t R_RX   = 3'b101;
    localparam rights_t R_X    = 3'b100;
    localparam rights_t R_RWX  = 3'b111;

    localparam int CODE_PROT = 8;
    localparam int CODE_PRIV = 12;

    // Rights granted by a permission code at a privilege level.
    function automatic rights_t code_rights(input logic is_user, input logic [2:0] code);
        rights_t r;
        case (code)
            3'd0: r = R_R;
            3'd1: r = R_RW;
            3'd2: r = R_RX;
            3'd3: r = R_RWX;
            3'd4: r = R_X;
            3'd5: r = is_user ? R_R : R_RW;
            3'd6: r = is_user ? R_NONE : R_RX;
            default: r = is_user ? R_NONE : R_RWX;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ppc_perm_eval.sv
module ppc_perm_eval
    import ppc_pkg::*;
#(
    parameter int STAT_W = 10
) (
    input  logic                acc_write,
    input  logic                acc_fetch,
    input  logic                acc_super,
    input  logic [2:0]          perm_code,
    input  logic                modified,
    input  logic                nofault_mode,
    input  logic [STAT_W-1:0]   walk_code,
    output logic [CLASS_W-1:0]  acc_class,
    output logic                is_fault,
    output logic [STAT_W-1:0]   fault_code,
    output rights_t             granted
);

    logic        is_user;
    rights_t     have;
    rights_t     need;
    logic [STAT_W-1:0] perm_code_out;
    logic        walk_fault;
    logic        perm_fault;

    always_comb begin
        is_user   = !acc_super;
        acc_class = {acc_write, acc_fetch, acc_super};
        have      = code_rights(is_user, perm_code);

        need = R_NONE;
        if (acc_write) need[WR_BIT] = 1'b1;
        if (acc_fetch) need[EX_BIT] = 1'b1;
        if (!acc_write && !acc_fetch) need[RD_BIT] = 1'b1;

        if (is_user && (perm_code[2:1] == 2'b11))
            perm_code_out = STAT_W'(CODE_PRIV);
        else if ((need & ~have) != R_NONE)
            perm_code_out = STAT_W'(CODE_PROT);
        else
            perm_code_out = '0;

        walk_fault = (walk_code != '0);
        perm_fault = (perm_code_out != '0) && !(nofault_mode && is_user);

        is_fault   = walk_fault || perm_fault;
        fault_code = walk_fault ? walk_code : perm_code_out;

        granted = have;
        if (!modified) granted[WR_BIT] = 1'b0;
    end

endmodule

// File: rtl/ppc_fault_log.sv
module ppc_fault_log
    import ppc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int STAT_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                log_en,
    input  logic                clr_status,
    input  logic [CLASS_W-1:0]  acc_class,
    input  logic [STAT_W-1:0]   fault_code,
    input  logic [ADDR_W-1:0]   fault_vaddr,
    output logic [STAT_W-1:0]   status_q,
    output logic [ADDR_W-1:0]   addr_q
);

    localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((64'd1 << PAGE_BITS) - 64'd1);
    localparam logic [STAT_W-1:0] OVF_FLAG  = STAT_W'(1);
    localparam logic [STAT_W-1:0] AV_FLAG   = STAT_W'(2);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [ADDR_W-1:0] addr;
    } log_t;

    log_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (clr_status) nxt_d.status = '0;
        if (log_en) begin
            nxt_d.status = (nxt_d.status != '0) ? OVF_FLAG : '0;
            nxt_d.status = nxt_d.status
                         | (STAT_W'(acc_class) << CLASS_LSB)
                         | fault_code
                         | AV_FLAG;
            nxt_d.addr   = fault_vaddr & ~PAGE_MASK;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign status_q = cur_q.status;
    assign addr_q   = cur_q.addr;

endmodule

// File: rtl/page_perm_check.sv
module page_perm_check
    import ppc_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int STAT_W    = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                acc_write,
    input  logic                acc_fetch,
    input  logic                acc_super,
    input  logic [2:0]          perm_code,
    input  logic                modified,
    input  logic                nofault_mode,
    input  logic                traps_en,
    input  logic [STAT_W-1:0]   walk_code,
    input  logic [ADDR_W-1:0]   fault_vaddr,
    input  logic                rd_en,
    input  logic                rd_sel,
    output logic [ADDR_W-1:0]   rd_data,
    output logic                resp_valid,
    output logic [2:0]          grant,
    output logic                ifault,
    output logic                dfault
);

    typedef struct packed {
        logic    valid;
        rights_t grant;
        logic    ifault;
        logic    dfault;
    } resp_t;

    logic [CLASS_W-1:0] acc_class;
    logic               is_fault;
    logic [STAT_W-1:0]  fault_code;
    rights_t            granted;
    logic               log_en;
    logic               clr_status;
    logic [STAT_W-1:0]  status_q;
    logic [ADDR_W-1:0]  addr_q;
    resp_t              resp_d, resp_q;

    ppc_perm_eval #(.STAT_W(STAT_W)) eval_i (
        .acc_write    (acc_write),
        .acc_fetch    (acc_fetch),
        .acc_super    (acc_super),
        .perm_code    (perm_code),
        .modified     (modified),
        .nofault_mode (nofault_mode),
        .walk_code    (walk_code),
        .acc_class    (acc_class),
        .is_fault     (is_fault),
        .fault_code   (fault_code),
        .granted      (granted)
    );

    assign log_en     = req_valid && is_fault;
    assign clr_status = rd_en && !rd_sel;

    ppc_fault_log #(
        .ADDR_W    (ADDR_W),
        .PAGE_BITS (PAGE_BITS),
        .STAT_W    (STAT_W)
    ) log_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .log_en      (log_en),
        .clr_status  (clr_status),
        .acc_class   (acc_class),
        .fault_code  (fault_code),
        .fault_vaddr (fault_vaddr),
        .status_q    (status_q),
        .addr_q      (addr_q)
    );

    always_comb begin
        logic trap;
        trap = is_fault && !nofault_mode && traps_en;
        resp_d = '0;
        resp_d.valid = req_valid;
        if (req_valid) begin
            if (!is_fault)  resp_d.grant = granted;
            else if (!trap) resp_d.grant = R_RWX;
            resp_d.ifault = trap && acc_fetch;
            resp_d.dfault = trap && !acc_fetch;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign rd_data    = rd_sel ? addr_q : ADDR_W'(status_q);
    assign resp_valid = resp_q.valid;
    assign grant      = resp_q.grant;
    assign ifault     = resp_q.ifault;
    assign dfault     = resp_q.dfault;

endmodule

// File: rtl/ppc_checker.sv
module ppc_checker #(
    parameter int ADDR_W = 32,
    parameter int STAT_W = 10
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               acc_fetch,
    input logic               resp_valid,
    input logic [2:0]         grant,
    input logic               ifault,
    input logic               dfault,
    input logic               log_en,
    input logic               clr,
    input logic [STAT_W-1:0]  status,
    input logic [ADDR_W-1:0]  fault_addr
);

    assert_one_trap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ifault, dfault}));

    assert_trap_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ifault || dfault) |-> (grant == 3'b000));

    assert_fetch_not_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && acc_fetch) |=> !dfault);

    assert_resp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    assert_resp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !resp_valid);

    assert_valid_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        log_en |=> status[1]);

    assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !log_en |=> $stable(fault_addr));

    assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (log_en && !clr && (status != '0)) |=> status[0]);

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !log_en) |=> (status == '0));

endmodule

bind page_perm_check ppc_checker #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acc_fetch  (acc_fetch),
    .resp_valid (resp_valid),
    .grant      (grant),
    .ifault     (ifault),
    .dfault     (dfault),
    .log_en     (log_en),
    .clr        (clr_status),
    .status     (status_q),
    .fault_addr (addr_q)
);

// File: tb/page_perm_check_tb_top.sv
`timescale 1ns/1ps
module page_perm_check_tb_top;

    localparam int ADDR_W = 32;
    localparam int STAT_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, acc_write = 0, acc_fetch = 0, acc_super = 0;
    logic [2:0] perm_code = 0;
    logic modified = 0, nofault_mode = 0, traps_en = 0;
    logic [STAT_W-1:0] walk_code = 0;
    logic [ADDR_W-1:0] fault_vaddr = 0;
    logic rd_en = 0, rd_sel = 0;
    logic [ADDR_W-1:0] rd_data;
    logic resp_valid;
    logic [2:0] grant;
    logic ifault, dfault;

    always #2.5 clk = ~clk;

    page_perm_check #(.ADDR_W(ADDR_W), .PAGE_BITS(12), .STAT_W(STAT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_super(acc_super),
        .perm_code(perm_code), .modified(modified), .nofault_mode(nofault_mode),
        .traps_en(traps_en), .walk_code(walk_code), .fault_vaddr(fault_vaddr),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data),
        .resp_valid(resp_valid), .grant(grant), .ifault(ifault), .dfault(dfault)
    );

    typedef struct {
        logic [2:0] grant;
        logic       ifl;
        logic       dfl;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fail = 0;
    logic [STAT_W-1:0] m_status = 0;
    logic [ADDR_W-1:0] m_addr = 0;

    function automatic logic [2:0] b_rights(input logic user, input logic [2:0] c);
        case (c)
            3'd0: return 3'b001;
            3'd1: return 3'b011;
            3'd2: return 3'b101;
            3'd3: return 3'b111;
            3'd4: return 3'b100;
            3'd5: return user ? 3'b001 : 3'b011;
            3'd6: return user ? 3'b000 : 3'b101;
            default: return user ? 3'b000 : 3'b111;
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_req(input logic w, input logic f, input logic s, input logic [2:0] c,
                          input logic mod, input logic nf, input logic te,
                          input logic [STAT_W-1:0] wc, input logic [ADDR_W-1:0] va,
                          input logic with_rd, input string tag);
        exp_t e;
        logic [2:0] need, have;
        logic [STAT_W-1:0] fc;
        logic user, trap;
        user = !s;
        have = b_rights(user, c);
        need = {f, w, !(w || f)};
        if (user && c >= 3'd6) fc = 12;
        else if ((need & ~have) != 0) fc = 8;
        else fc = 0;
        if (nf && user) fc = 0;
        if (wc != 0) fc = wc;
        @(negedge clk);
        req_valid = 1; acc_write = w; acc_fetch = f; acc_super = s; perm_code = c;
        modified = mod; nofault_mode = nf; traps_en = te; walk_code = wc; fault_vaddr = va;
        if (with_rd) begin
            rd_en = 1; rd_sel = 0;
            #1;
            check(rd_data == ADDR_W'(m_status), {tag, " read-with-fault R11"}, rd_data, m_status);
            m_status = 0;
        end
        e.tag = tag;
        if (fc != 0) begin
            m_status = ((m_status != 0) ? STAT_W'(1) : STAT_W'(0)) | (STAT_W'({w, f, s}) << 5) | fc | STAT_W'(2);
            m_addr = va & ~32'hfff;
            trap = !nf && te;
            e.grant = trap ? 3'b000 : 3'b111;
            e.ifl = trap && f;
            e.dfl = trap && !f;
        end else begin
            e.grant = have & (mod ? 3'b111 : 3'b101);
            e.ifl = 0;
            e.dfl = 0;
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 0; rd_en = 0;
    endtask

    task automatic rd_check(input logic sel, input string tag);
        logic [ADDR_W-1:0] expv;
        @(negedge clk);
        rd_en = 1; rd_sel = sel;
        #1;
        expv = sel ? m_addr : ADDR_W'(m_status);
        check(rd_data == expv, tag, rd_data, expv);
        if (!sel) m_status = 0;
        @(negedge clk);
        rd_en = 0;
    endtask

    // Monitor: pop and compare each response
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (resp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "unexpected response R10", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check({grant, ifault, dfault} == {e.grant, e.ifl, e.dfl}, e.tag,
                          {grant, ifault, dfault}, {e.grant, e.ifl, e.dfl});
                end
            end
        end
    end

    initial begin
        #400000;
        check(1'b0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check({resp_valid, grant, ifault, dfault} == 0, "reset outputs R12", {resp_valid, grant, ifault, dfault}, 0);
        rst_n = 1;
        rd_check(0, "reset status R12");
        rd_check(1, "reset address R12");

        // Full sweep of access class x permission code (R1 R2 R3 R8)
        for (int cls = 0; cls < 8; cls++) begin
            for (int c = 0; c < 8; c++) begin
                logic [2:0] cl;
                cl = 3'(cls);
                do_req(cl[2], cl[1], cl[0], 3'(c), 1, 0, 1, 0,
                       32'h1234_5abc + (32'(cls * 8 + c) << 12), 0, "sweep R2 R3 R9");
            end
            rd_check(0, "sweep status accumulate R1 R7 R8");
            rd_check(1, "sweep address R7");
        end

        // Single clean fault: field layout, user write code 0 -> 8 (R1 R7)
        do_req(1, 0, 0, 3'd0, 1, 0, 1, 0, 32'hdead_beef, 0, "user write prot R3");
        rd_check(1, "page aligned address R7");
        rd_check(1, "address read keeps R11");
        rd_check(0, "status layout R1 R7");
        rd_check(0, "status cleared after read R11");

        // Modified bit masking (R4)
        do_req(1, 0, 1, 3'd1, 0, 0, 1, 0, 32'h100, 0, "write unmodified masks W R4");
        do_req(0, 0, 1, 3'd3, 0, 0, 1, 0, 32'h200, 0, "read unmodified RX R4");
        rd_check(0, "no fault logged R4");

        // No-fault mode suppression for user, not for supervisor (R5)
        do_req(0, 0, 0, 3'd6, 1, 1, 1, 0, 32'h3000, 0, "user nofault suppressed R5");
        rd_check(0, "suppressed fault not logged R5");
        do_req(1, 0, 1, 3'd0, 1, 1, 1, 0, 32'h4000, 0, "super nofault grants RWX R9");
        rd_check(0, "super nofault logged R9");

        // Traps disabled (R9)
        do_req(0, 1, 0, 3'd0, 1, 0, 0, 0, 32'h5000, 0, "traps off grants RWX R9");
        do_req(0, 1, 0, 3'd0, 1, 0, 1, 0, 32'h6000, 0, "fetch trap ifault R9");
        rd_check(0, "two faults overflow R8");

        // Walk fault skips permission check, not suppressed (R6)
        do_req(0, 0, 0, 3'd3, 1, 1, 1, 10'h104, 32'h7000, 0, "walk fault nofault R6");
        do_req(0, 0, 1, 3'd3, 1, 0, 1, 10'h310, 32'h8000, 0, "walk fault trap R6");
        rd_check(0, "walk code in status R6 R8");

        // Read and fault in the same cycle (R11)
        do_req(1, 0, 0, 3'd2, 1, 0, 1, 0, 32'h9000, 0, "pre fault R11");
        do_req(0, 1, 1, 3'd0, 1, 0, 1, 0, 32'ha000, 1, "fault with read R11");
        rd_check(0, "no overflow after same-cycle read R11");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "all responses seen R10", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule